// File: doc/BRIEF.md
# Motor Start and Stall Protection Supervisor

This block decides when a brushless motor's power stage may drive. A start/stop input chooses between a free-wheeling, low-power stop condition and start mode. Each start request first runs a fixed initial-reset interval. Only then is drive enabled. While the motor is driven, the block watches two pulse streams: the speed-reference clock and the FG pulse train derived from the first Hall sensor. Both watchdogs count ticks of a slow timebase rather than system-clock cycles.

If the reference clock stops changing for a short window, normal speed control is dropped. The drive enable then pulses on and off, changing on every timebase tick, until the clock comes back. If no FG rising edge arrives within a longer window, the rotor is taken to be blocked. The block then removes drive and latches a fault. Only a return to stop mode or a power-on reset clears that fault.

The states are ST_STOP, ST_INIT, ST_RUN, ST_PULSE and ST_FAULT. The transitions are:
- start (ST_STOP to ST_INIT)
- init_done (ST_INIT to ST_RUN)
- clk_lost (ST_RUN to ST_PULSE)
- clk_back (ST_PULSE to ST_RUN)
- stalled (ST_RUN or ST_PULSE to ST_FAULT)
- stop (any state to ST_STOP)

Top module: `motor_start_supervisor`

## Requirements
- R1: While rst_n is low, and in every cycle after a sampled high stop_req, power_save is 1 and drive_en and stall_fault are 0 (stop_req high means stop; a pulled-up open input therefore reads as stop).
- R2: A low stop_req sampled in ST_STOP enters ST_INIT. drive_en stays 0 for RESET_CYCLES clock cycles from that edge and becomes 1 on the following edge.
- R3: In ST_RUN or ST_PULSE, STALL_TICKS tick pulses without an FG rising edge cause drive_en to go to 0 and stall_fault to go to 1 on the edge that samples the last tick.
- R4: An FG rising edge (fg_in 0 then 1 on consecutive samples) restarts the stall window. A falling edge does not restart it.
- R5: Once set, stall_fault stays 1 until stop_req is sampled high or rst_n is asserted. FG edges and ticks do not clear it.
- R6: In ST_RUN, LOSS_TICKS tick pulses without any ref_clk level change move the block to ST_PULSE. At that point intermittent becomes 1 and drive_en becomes 0.
- R7: In ST_PULSE, drive_en inverts on each sampled tick and holds in cycles without a tick.
- R8: A ref_clk level change sampled in ST_PULSE returns the block to ST_RUN on that edge, with intermittent 0 and drive_en 1.
- R9: In ST_FAULT, ref_clk changes do not re-enable drive_en.
- R10: When the stall window and the clock-loss window expire on the same tick, ST_FAULT is taken, not ST_PULSE.
- R11: A high stop_req sampled in any state, including ST_PULSE and ST_FAULT, gives power_save 1, with intermittent, stall_fault and drive_en 0, on that edge.
- R12: At most one of power_save, intermittent and stall_fault is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| stop_req | input | 1 | 1 = stop mode, 0 = start mode |
| tick | input | 1 | One-cycle timebase pulse |
| ref_clk | input | 1 | Speed reference clock, sampled level |
| fg_in | input | 1 | Hall-derived FG level, sampled |
| drive_en | output | 1 | Power stage enable |
| intermittent | output | 1 | 1 while running in clock-loss pulsed mode |
| stall_fault | output | 1 | Latched locked-rotor fault |
| power_save | output | 1 | 1 in stop mode |

## Verification
Every output is registered from the next state, so a wrong state or counter value shows at the ports on the edge that follows the bad decision. A stall counter that is off by one moves the fault by exactly one tick. An edge detector that accepts the wrong polarity either leaves a fault missing or raises one that should not occur. Either error shows within one stall window. A wrong toggle phase in pulsed mode shows at the first tick after clock loss. The bench therefore compares all four outputs against a behavioural model on every cycle. It also aims scenarios at the exact tick where each window closes.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [2:0] {
        ST_STOP,
        ST_INIT,
        ST_RUN,
        ST_PULSE,
        ST_FAULT
    } sup_state_t;
endpackage

// File: rtl/sup_edge.sv
// Edge detector on a sampled level: rising only, or both polarities.
module sup_edge #(
    parameter bit ANY_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    generate
        if (ANY_EDGE) begin : g_any
            assign edge_o = sig ^ prev_q;
        end else begin : g_rise
            assign edge_o = sig & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/sup_window.sv
// Saturating event counter: hit fires on the LIMIT-th inc while active.
module sup_window #(
    parameter int LIMIT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign hit = active & inc & ~clr & (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!active || clr)   cnt_q <= '0;
        else if (inc && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/motor_start_supervisor.sv
module motor_start_supervisor
    import sup_pkg::*;
#(
    parameter int RESET_CYCLES = 16,
    parameter int STALL_TICKS  = 31,
    parameter int LOSS_TICKS   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic tick,
    input  logic ref_clk,
    input  logic fg_in,
    output logic drive_en,
    output logic intermittent,
    output logic stall_fault,
    output logic power_save
);
    sup_state_t state_q, state_d;
    logic fg_rise, ref_edge;
    logic watching, in_init;
    logic init_done, stall_hit, loss_hit;

    assign watching = (state_q == ST_RUN) || (state_q == ST_PULSE);
    assign in_init  = (state_q == ST_INIT);

    sup_edge #(.ANY_EDGE(1'b0)) u_fg_edge (
        .clk(clk), .rst_n(rst_n), .sig(fg_in), .edge_o(fg_rise)
    );

    sup_edge #(.ANY_EDGE(1'b1)) u_ref_edge (
        .clk(clk), .rst_n(rst_n), .sig(ref_clk), .edge_o(ref_edge)
    );

    sup_window #(.LIMIT(RESET_CYCLES)) u_init_win (
        .clk(clk), .rst_n(rst_n), .active(in_init),
        .clr(1'b0), .inc(1'b1), .hit(init_done)
    );

    sup_window #(.LIMIT(STALL_TICKS)) u_stall_win (
        .clk(clk), .rst_n(rst_n), .active(watching),
        .clr(fg_rise), .inc(tick), .hit(stall_hit)
    );

    sup_window #(.LIMIT(LOSS_TICKS)) u_loss_win (
        .clk(clk), .rst_n(rst_n), .active(watching),
        .clr(ref_edge), .inc(tick), .hit(loss_hit)
    );

    always_comb begin
        state_d = state_q;
        if (stop_req) begin
            state_d = ST_STOP;
        end else begin
            unique case (state_q)
                ST_STOP:  state_d = ST_INIT;
                ST_INIT:  if (init_done) state_d = ST_RUN;
                ST_RUN: begin
                    if (stall_hit)     state_d = ST_FAULT;
                    else if (loss_hit) state_d = ST_PULSE;
                end
                ST_PULSE: begin
                    if (stall_hit)     state_d = ST_FAULT;
                    else if (ref_edge) state_d = ST_RUN;
                end
                ST_FAULT: state_d = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_en     <= 1'b0;
            intermittent <= 1'b0;
            stall_fault  <= 1'b0;
            power_save   <= 1'b1;
        end else begin
            drive_en     <= (state_d == ST_RUN) ||
                            ((state_d == ST_PULSE) && (state_q == ST_PULSE) &&
                             (drive_en ^ tick));
            intermittent <= (state_d == ST_PULSE);
            stall_fault  <= (state_d == ST_FAULT);
            power_save   <= (state_d == ST_STOP);
        end
    end
endmodule

// File: rtl/sup_chk.sv
module sup_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic tick,
    input logic drive_en,
    input logic intermittent,
    input logic stall_fault,
    input logic power_save
);
    // R1
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |-> (!drive_en && !stall_fault));

    // R2
    init_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_save) |-> !drive_en);

    // R3
    fault_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fault |-> !drive_en);

    // R5
    fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_fault && !stop_req) |=> stall_fault);

    // R7
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intermittent && !tick && !stop_req) |=>
            (!intermittent || drive_en == $past(drive_en)));

    // R11
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (power_save && !drive_en && !intermittent));

    // R12
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({power_save, intermittent, stall_fault}));
endmodule

bind motor_start_supervisor sup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .tick(tick),
    .drive_en(drive_en), .intermittent(intermittent),
    .stall_fault(stall_fault), .power_save(power_save)
);

// File: tb/sim_motor_start_supervisor.sv
module sim_motor_start_supervisor;
    localparam int PER   = 10;
    localparam int RCYC  = 4;
    localparam int STALL = 31;
    localparam int LOSS  = 2;

    logic clk = 1'b0, rst_n = 1'b0, stop_req = 1'b1, tick = 1'b0;
    logic ref_clk = 1'b0, fg_in = 1'b0;
    logic drive_en, intermittent, stall_fault, power_save;
    int checks = 0, errors = 0;

    always #(PER/2) clk = ~clk;

    motor_start_supervisor #(.RESET_CYCLES(RCYC), .STALL_TICKS(STALL), .LOSS_TICKS(LOSS)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .tick(tick),
        .ref_clk(ref_clk), .fg_in(fg_in), .drive_en(drive_en),
        .intermittent(intermittent), .stall_fault(stall_fault), .power_save(power_save)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: mode 0 stop,1 init,2 run,3 pulsed,4 fault
    int  m_mode = 0, m_scnt = 0, m_lcnt = 0, m_icnt = 0;
    bit  m_drive = 0, m_pf = 0, m_pr = 0, m_live = 0;
    bit  fr, re, act_w, sh, lh, ih;
    int  nm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_scnt = 0; m_lcnt = 0; m_icnt = 0;
            m_drive = 0; m_pf = 0; m_pr = 0; m_live = 1;
        end else begin
            fr    = fg_in && !m_pf;
            re    = (ref_clk != m_pr);
            act_w = (m_mode == 2) || (m_mode == 3);
            sh    = act_w && tick && !fr && (m_scnt == STALL - 1);
            lh    = act_w && tick && !re && (m_lcnt == LOSS - 1);
            ih    = (m_mode == 1) && (m_icnt == RCYC - 1);
            nm    = m_mode;
            if (stop_req) nm = 0;
            else if (m_mode == 0) nm = 1;
            else if (m_mode == 1 && ih) nm = 2;
            else if (m_mode == 2 && sh) nm = 4;
            else if (m_mode == 2 && lh) nm = 3;
            else if (m_mode == 3 && sh) nm = 4;
            else if (m_mode == 3 && re) nm = 2;
            if (nm == 2) m_drive = 1;
            else if (nm == 3 && m_mode == 3) m_drive = tick ? !m_drive : m_drive;
            else m_drive = 0;
            if (!act_w || fr) m_scnt = 0;
            else if (tick && m_scnt < STALL - 1) m_scnt++;
            if (!act_w || re) m_lcnt = 0;
            else if (tick && m_lcnt < LOSS - 1) m_lcnt++;
            if (m_mode != 1) m_icnt = 0;
            else if (m_icnt < RCYC - 1) m_icnt++;
            m_mode = nm;
            m_pf = fg_in; m_pr = ref_clk;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk("R1 power_save model", power_save, m_mode == 0);
            chk("R6 intermittent model", intermittent, m_mode == 3);
            chk("R5 stall_fault model", stall_fault, m_mode == 4);
            chk("R7 drive_en model", drive_en, m_drive);
            chk("R12 flag exclusivity", $countones({power_save, intermittent, stall_fault}) <= 1, 1'b1);
        end
    end

    task automatic cyc(input logic t, input logic rt, input logic f);
        tick = t;
        if (rt) ref_clk = ~ref_clk;
        fg_in = f;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic start_run();
        stop_req = 1'b0;
        repeat (RCYC + 1) cyc(0, 1, 0);
    endtask

    initial begin
        #(PER * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset power_save", power_save, 1'b1);
        chk("R1 reset drive_en", drive_en, 1'b0);
        rst_n = 1'b1;
        cyc(0, 0, 0);
        chk("R1 stop power_save", power_save, 1'b1);
        chk("R1 stop drive_en", drive_en, 1'b0);

        // R2 initial reset length
        stop_req = 1'b0;
        cyc(0, 1, 0);
        chk("R2 init leaves stop", power_save, 1'b0);
        chk("R2 init drive off", drive_en, 1'b0);
        repeat (RCYC - 1) cyc(0, 1, 0);
        chk("R2 last init cycle drive off", drive_en, 1'b0);
        cyc(0, 1, 0);
        chk("R2 drive on after init", drive_en, 1'b1);

        // R4 rise restarts window, fall does not
        repeat (STALL - 1) cyc(1, 1, 0);
        chk("R4 no fault before window", stall_fault, 1'b0);
        cyc(0, 1, 1);
        cyc(0, 1, 0);
        repeat (STALL - 1) cyc(1, 1, 0);
        chk("R4 rise restarted window", stall_fault, 1'b0);
        chk("R4 drive still on", drive_en, 1'b1);
        // R3 stall expiry
        cyc(1, 1, 0);
        chk("R3 fault set", stall_fault, 1'b1);
        chk("R3 drive removed", drive_en, 1'b0);

        // R9 / R5 fault sticks
        repeat (4) cyc(0, 1, 0);
        cyc(0, 1, 1);
        cyc(1, 1, 0);
        chk("R9 clock return no restart", drive_en, 1'b0);
        chk("R5 fault held", stall_fault, 1'b1);

        // R5 / R11 stop clears fault
        stop_req = 1'b1;
        cyc(0, 1, 0);
        chk("R11 stop from fault", power_save, 1'b1);
        chk("R5 fault cleared by stop", stall_fault, 1'b0);
        start_run();
        chk("R2 restart drive on", drive_en, 1'b1);

        // R6 clock loss
        cyc(1, 0, 1);
        chk("R6 one tick not yet lost", intermittent, 1'b0);
        cyc(1, 0, 0);
        chk("R6 intermittent set", intermittent, 1'b1);
        chk("R6 drive off on entry", drive_en, 1'b0);

        // R7 toggling
        cyc(1, 0, 1);
        chk("R7 tick toggles on", drive_en, 1'b1);
        cyc(0, 0, 0);
        chk("R7 no tick holds", drive_en, 1'b1);
        cyc(1, 0, 1);
        chk("R7 tick toggles off", drive_en, 1'b0);

        // R8 clock returns
        cyc(0, 1, 0);
        chk("R8 intermittent cleared", intermittent, 1'b0);
        chk("R8 drive resumes", drive_en, 1'b1);

        // R10 simultaneous expiry
        cyc(0, 1, 1);
        repeat (STALL - 2) cyc(1, 1, 1);
        cyc(1, 0, 1);
        chk("R10 still running", drive_en, 1'b1);
        cyc(1, 0, 1);
        chk("R10 fault wins", stall_fault, 1'b1);
        chk("R10 not intermittent", intermittent, 1'b0);

        // R11 stop from pulsed mode
        stop_req = 1'b1;
        cyc(0, 1, 0);
        start_run();
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R11 pre-check pulsed", intermittent, 1'b1);
        stop_req = 1'b1;
        cyc(0, 0, 0);
        chk("R11 stop from pulsed", power_save, 1'b1);
        chk("R11 intermittent cleared", intermittent, 1'b0);
        chk("R11 drive off", drive_en, 1'b0);

        // R1 reset during run
        start_run();
        rst_n = 1'b0;
        cyc(0, 1, 0);
        chk("R1 reset mid-run power_save", power_save, 1'b1);
        chk("R1 reset mid-run drive", drive_en, 1'b0);
        rst_n = 1'b1;
        cyc(0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule